// File: doc/BRIEF.md
# Dual GPIO Port with Masked Pattern-Mismatch Wake and Interrupt

This block holds two 8-bit general-purpose I/O ports. Each port has five registers: a latched output value, a per-pin digital/analog select, a per-pin push-pull/open-drain select, a compare mask and a compare value. The registers sit on a simple single-cycle register bus. The pad side is modelled per pin as an output enable, an output level, a weak pull-up enable and an input level.

The pin inputs first pass through a two-stage synchronizer. The same synchronized levels are then used by two paths: register reads of the port value, and a comparator. The comparator flags a mismatch on a port when the masked pin levels differ from the masked compare value. Mismatches from both ports are ORed into one level-sensitive event. That event raises an interrupt request only while an enable bit is set. It also always issues a one-cycle wake pulse when it becomes active, so a suspended clock source can be restarted. The comparison does not depend on how pins are assigned to peripherals.

Top module: `gpio_match_port`

## Requirements
- R1: After reset, every output-latch and digital-select register holds 0xFF, and every push-pull, mask and compare register holds 0x00. The interrupt enable is 0. At the pads this gives pad_oe = 0 and pad_pullup all ones, with irq_req and wake_pulse low.
- R2: The register address is {port index, select[2:0]}, where port 0 is at 0-7 and port 1 is at 8-15. The select values are 0 output latch/pin value, 1 digital select, 2 push-pull select, 3 mask, 4 compare value, and 5 on port 0 only, whose bit 0 is the interrupt enable. Every other address reads 0 and ignores writes. A write takes effect after the clock edge that samples it.
- R3: A read at select 0 returns the synchronized pin level for pins whose digital-select bit is 1, and 0 for pins whose digital-select bit is 0. A pin change becomes visible to reads after two rising clock edges.
- R4: For a digital pin, a latch bit of 0 drives the pad low (oe=1, out=0). A latch bit of 1 with push-pull bit 1 drives it high (oe=1, out=1). A latch bit of 1 with push-pull bit 0 leaves the pad undriven (oe=0).
- R5: A pin whose digital-select bit is 0 has its output enable and its pull-up both 0, whatever its latch value.
- R6: The pull-up of a pin is enabled exactly when the pin is digital and its latch bit is 1, that is, when the pin is not driven low.
- R7: A port mismatches when (seen & mask) != (compare & mask). Here "seen" is the synchronized pin level, forced to 0 for analog pins. The event is a level: it clears as soon as the masked values agree again.
- R8: irq_req equals the mismatch event ANDed with the interrupt enable.
- R9: wake_pulse is high for exactly one cycle, in the first cycle the mismatch event is active. This happens whatever the interrupt enable is set to.
- R10: A mismatch on either port alone asserts the event, so bits 15:8 and bits 7:0 of pad_in each count on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | {port index, register select} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 16 | Pin levels; 7:0 port 0, 15:8 port 1 |
| pad_oe | output | 16 | Per-pin output driver enable |
| pad_out | output | 16 | Per-pin output level |
| pad_pullup | output | 16 | Per-pin weak pull-up enable |
| irq_req | output | 1 | Mismatch interrupt request (level) |
| wake_pulse | output | 1 | One-cycle wake request on mismatch onset |

## Verification
The checker runs on every cycle and checks the pad rules: analog pins are never driven or pulled up, open-drain pins never drive high, and a pin driven low has no pull-up. It also checks that the interrupt never asserts without both the event and the enable, and that the wake pulse lasts one cycle and coincides with the event. Some behaviour can only be shown by the bench scenarios, because it depends on register contents chosen through the bus and on the pin patterns driven. This covers the exact mismatch decision for each masked pin pattern, the two-edge latency of the synchronizer, gating of analog pins in reads, and the reset values seen through the bus.

// File: rtl/gpio_match_pkg.sv
package gpio_match_pkg;

    localparam int PIN_W = 8;
    localparam int SEL_W = 3;

    typedef logic [PIN_W-1:0] pin_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_LATCH    = 3'd0,
        SEL_DIGITAL  = 3'd1,
        SEL_PUSHPULL = 3'd2,
        SEL_CARE     = 3'd3,
        SEL_EXPECT   = 3'd4,
        SEL_CTRL     = 3'd5
    } reg_sel_e;

    typedef struct packed {
        pin_vec_t latch;
        pin_vec_t digital;
        pin_vec_t push_pull;
        pin_vec_t care;
        pin_vec_t expect_v;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{
        latch:     '1,
        digital:   '1,
        push_pull: '0,
        care:      '0,
        expect_v:  '0
    };

    typedef struct packed {
        logic oe;
        logic dout;
        logic pull;
    } pad_ctl_t;

    function automatic pad_ctl_t pad_drive(logic dig, logic pp, logic lat);
        pad_ctl_t r;
        r.dout = lat;
        r.oe   = dig & (~lat | pp);
        r.pull = dig & lat;
        return r;
    endfunction

    function automatic logic port_mismatch(pin_vec_t seen, pin_vec_t care, pin_vec_t expect_v);
        return (seen & care) != (expect_v & care);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_match_pkg::*;
#(
    parameter int NPORTS = 2,
    localparam int PIX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int AW    = PIX_W + SEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  pin_vec_t        bus_wdata,
    output pin_vec_t        bus_rdata,
    input  pin_vec_t        seen [NPORTS],
    output port_cfg_t       cfg  [NPORTS],
    output logic            irq_en
);
    logic [PIX_W-1:0] pidx;
    reg_sel_e         rsel;
    logic             wr_hit;

    assign pidx   = bus_addr[AW-1:SEL_W];
    assign rsel   = reg_sel_e'(bus_addr[SEL_W-1:0]);
    assign wr_hit = bus_sel & bus_wr;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[p] <= CFG_RESET;
            end else if (wr_hit && pidx == PIX_W'(p)) begin
                case (rsel)
                    SEL_LATCH:    cfg[p].latch     <= bus_wdata;
                    SEL_DIGITAL:  cfg[p].digital   <= bus_wdata;
                    SEL_PUSHPULL: cfg[p].push_pull <= bus_wdata;
                    SEL_CARE:     cfg[p].care      <= bus_wdata;
                    SEL_EXPECT:   cfg[p].expect_v  <= bus_wdata;
                    default:      ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en <= 1'b0;
        end else if (wr_hit && pidx == '0 && rsel == SEL_CTRL) begin
            irq_en <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (pidx == PIX_W'(p)) begin
                case (rsel)
                    SEL_LATCH:    bus_rdata = seen[p];
                    SEL_DIGITAL:  bus_rdata = cfg[p].digital;
                    SEL_PUSHPULL: bus_rdata = cfg[p].push_pull;
                    SEL_CARE:     bus_rdata = cfg[p].care;
                    SEL_EXPECT:   bus_rdata = cfg[p].expect_v;
                    SEL_CTRL:     bus_rdata = (p == 0) ? {{(PIN_W-1){1'b0}}, irq_en} : '0;
                    default:      bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_match_pkg::*;
(
    input  port_cfg_t cfg,
    output pin_vec_t  oe,
    output pin_vec_t  dout,
    output pin_vec_t  pull
);
    for (genvar b = 0; b < PIN_W; b++) begin : g_pin
        pad_ctl_t ctl;
        assign ctl     = pad_drive(cfg.digital[b], cfg.push_pull[b], cfg.latch[b]);
        assign oe[b]   = ctl.oe;
        assign dout[b] = ctl.dout;
        assign pull[b] = ctl.pull;
    end
endmodule

// File: rtl/gpio_match_det.sv
module gpio_match_det
    import gpio_match_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pin_vec_t  seen [NPORTS],
    input  port_cfg_t cfg  [NPORTS],
    input  logic      irq_en,
    output logic      match_evt,
    output logic      irq_req,
    output logic      wake_pulse
);
    logic [NPORTS-1:0] port_hit;
    logic              evt_q;

    for (genvar p = 0; p < NPORTS; p++) begin : g_cmp
        assign port_hit[p] = port_mismatch(seen[p], cfg[p].care, cfg[p].expect_v);
    end

    assign match_evt = |port_hit;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= 1'b0;
        else     evt_q <= match_evt;
    end

    assign irq_req    = match_evt & irq_en;
    assign wake_pulse = match_evt & ~evt_q;
endmodule

// File: rtl/gpio_match_port.sv
module gpio_match_port
    import gpio_match_pkg::*;
#(
    parameter int NPORTS = 2,
    localparam int PIX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int AW    = PIX_W + SEL_W,
    localparam int TOT   = NPORTS * PIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [PIN_W-1:0] bus_wdata,
    output logic [PIN_W-1:0] bus_rdata,
    input  logic [TOT-1:0]   pad_in,
    output logic [TOT-1:0]   pad_oe,
    output logic [TOT-1:0]   pad_out,
    output logic [TOT-1:0]   pad_pullup,
    output logic             irq_req,
    output logic             wake_pulse
);
    port_cfg_t      cfg  [NPORTS];
    pin_vec_t       seen [NPORTS];
    logic [TOT-1:0] pin_sync;
    logic [TOT-1:0] digital_all;
    logic [TOT-1:0] push_pull_all;
    logic           irq_en;
    logic           match_evt;

    gpio_in_sync #(.W(TOT)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign seen[p] = pin_sync[p*PIN_W +: PIN_W] & cfg[p].digital;
        assign digital_all[p*PIN_W +: PIN_W]   = cfg[p].digital;
        assign push_pull_all[p*PIN_W +: PIN_W] = cfg[p].push_pull;

        gpio_pad_ctl i_pad (
            .cfg  (cfg[p]),
            .oe   (pad_oe[p*PIN_W +: PIN_W]),
            .dout (pad_out[p*PIN_W +: PIN_W]),
            .pull (pad_pullup[p*PIN_W +: PIN_W])
        );
    end

    gpio_regbank #(.NPORTS(NPORTS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .seen      (seen),
        .cfg       (cfg),
        .irq_en    (irq_en)
    );

    gpio_match_det #(.NPORTS(NPORTS)) i_det (
        .clk        (clk),
        .rst        (rst),
        .seen       (seen),
        .cfg        (cfg),
        .irq_en     (irq_en),
        .match_evt  (match_evt),
        .irq_req    (irq_req),
        .wake_pulse (wake_pulse)
    );
endmodule

// File: rtl/gpio_match_chk.sv
module gpio_match_chk #(
    parameter int TOT = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [TOT-1:0] pad_oe,
    input logic [TOT-1:0] pad_out,
    input logic [TOT-1:0] pad_pullup,
    input logic [TOT-1:0] digital_all,
    input logic [TOT-1:0] push_pull_all,
    input logic           match_evt,
    input logic           irq_en,
    input logic           irq_req,
    input logic           wake_pulse
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq_req && !wake_pulse && digital_all == '1 && pad_oe == '0));

    // R4
    open_drain_high_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & ~push_pull_all) == '0);

    // R5
    analog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_pullup) & ~digital_all) == '0);

    // R6
    pull_when_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_pullup & pad_oe & ~pad_out) == '0);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (match_evt && irq_en));

    // R9
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    // R9
    wake_onset_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> match_evt);
endmodule

bind gpio_match_port gpio_match_chk #(.TOT(TOT)) i_match_chk (
    .clk           (clk),
    .rst           (rst),
    .pad_oe        (pad_oe),
    .pad_out       (pad_out),
    .pad_pullup    (pad_pullup),
    .digital_all   (digital_all),
    .push_pull_all (push_pull_all),
    .match_evt     (match_evt),
    .irq_en        (irq_en),
    .irq_req       (irq_req),
    .wake_pulse    (wake_pulse)
);

// File: tb/test_gpio_match_port.sv
module test_gpio_match_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe, pad_out, pad_pullup;
    logic        irq_req, wake_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    gpio_match_port i_gpio_match_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pullup(pad_pullup), .irq_req(irq_req), .wake_pulse(wake_pulse)
    );

    always #2 clk = ~clk;

    // {port1 pins, port0 pins, expected event}; mask0=0F cmp0=05, mask1=F0 cmp1=A0
    localparam logic [16:0] VEC [8] = '{
        {8'hA0, 8'h05, 1'b0},
        {8'hAF, 8'hF5, 1'b0},
        {8'hA0, 8'h04, 1'b1},
        {8'hB0, 8'h05, 1'b1},
        {8'h00, 8'h00, 1'b1},
        {8'hA3, 8'h35, 1'b0},
        {8'h20, 8'h05, 1'b1},
        {8'hFF, 8'hFF, 1'b1}
    };

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(logic [15:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 oe", pad_oe, 16'h0000);
        check("R1 pullup", pad_pullup, 16'hFFFF);
        check("R1 irq", irq_req, 0);
        check("R1 wake", wake_pulse, 0);
        rd(4'd1, r);  check("R1 digital p0", r, 8'hFF);
        rd(4'd9, r);  check("R1 digital p1", r, 8'hFF);
        rd(4'd2, r);  check("R1 pushpull", r, 8'h00);
        rd(4'd11, r); check("R1 mask p1", r, 8'h00);
        rd(4'd12, r); check("R1 cmp p1", r, 8'h00);
        rd(4'd5, r);  check("R1 enable", r, 8'h00);

        // R2 address map and unused addresses
        wr(4'd6, 8'hFF);  rd(4'd6, r);  check("R2 unused 6", r, 8'h00);
        wr(4'd13, 8'hFF); rd(4'd13, r); check("R2 port1 ctrl", r, 8'h00);
        rd(4'd5, r); check("R2 enable untouched", r, 8'h00);
        wr(4'd3, 8'h0F); wr(4'd4, 8'h05);
        wr(4'd11, 8'hF0); wr(4'd12, 8'hA0);
        rd(4'd11, r); check("R2 mask p1", r, 8'hF0);
        rd(4'd4, r);  check("R2 cmp p0", r, 8'h05);
        wr(4'd5, 8'h01);
        rd(4'd5, r);  check("R2 enable", r, 8'h01);

        // R7 R8 R10 table walk
        foreach (VEC[i]) begin
            set_pins(VEC[i][16:1]);
            check($sformatf("R7 R10 vec%0d irq", i), irq_req, VEC[i][0]);
        end

        // R7 level clears once masked values agree
        set_pins(16'hA004);
        check("R7 set", irq_req, 1);
        set_pins(16'hA005);
        check("R7 clear", irq_req, 0);

        // R8 R9 enable off: no irq, wake still pulses once
        wr(4'd5, 8'h00);
        @(negedge clk) pad_in = 16'hA004;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 wake onset", wake_pulse, 1);
        check("R8 irq masked", irq_req, 0);
        @(negedge clk);
        check("R9 wake one cycle", wake_pulse, 0);
        set_pins(16'hA005);
        wr(4'd5, 8'h01);

        // R3 read latency and analog gating
        @(negedge clk) pad_in = 16'h3CA5;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd0;
        #1 check("R3 not yet", bus_rdata, 8'h05);
        bus_sel = 1'b0;
        @(posedge clk); @(negedge clk);
        bus_addr = 4'd0;
        #1 check("R3 after two edges", bus_rdata, 8'hA5);
        rd(4'd8, r); check("R3 port1", r, 8'h3C);
        wr(4'd1, 8'hF0);
        rd(4'd0, r); check("R3 analog gated", r, 8'hA0);

        // R7 analog pins seen as 0: mask 0F cmp 00 with pins high -> no event
        wr(4'd4, 8'h00);
        set_pins(16'hA0FF);
        check("R7 analog as zero", irq_req, 0);
        wr(4'd1, 8'hFF);
        @(negedge clk); @(negedge clk);
        check("R7 digital restored", irq_req, 1);
        wr(4'd3, 8'h00);

        // R4 R5 R6 pad control on port 0
        wr(4'd2, 8'h05); wr(4'd0, 8'h03);
        check("R4 oe", pad_oe[7:0], 8'hFD);
        check("R4 out", pad_out[7:0], 8'h03);
        check("R6 pull", pad_pullup[7:0], 8'h03);
        wr(4'd1, 8'hFE);
        check("R5 oe analog", pad_oe[7:0], 8'hFC);
        check("R5 pull analog", pad_pullup[7:0], 8'h02);
        check("R5 port1 unaffected", pad_pullup[15:8], 8'hFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule